// File: doc/BRIEF.md
# Store Queue with Load Forwarding Search

This block is a circular queue of in-flight stores for an out-of-order core. The rename stage allocates a slot for each store in program order and receives the slot index. Execution later fills in the store's address, size and data. Commit marks older stores as retired. Retired stores that carry data drain to memory one per cycle, in order, through a writeback port that memory can hold off. A slot is released only after its store has been written back.

Loads probe the queue before they go to the cache. A load presents the queue position that was recorded when it was dispatched, along with its own address and size. The queue walks from that position toward older stores and stops at the oldest store not yet written back. The youngest overlapping store decides the outcome. If that store covers the whole load, its bytes are returned. If it covers only part of the load and is unfinished, the load must stall and be replayed. If no store overlaps, the load goes to memory. The answer arrives one cycle after the probe.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_idx` is 0, `sq_full` is 0, `wb_valid` is 0 and `res_valid` is 0.
- R2: An accepted allocation takes slot `alloc_idx` and advances it by one modulo DEPTH. `sq_full` is 1 whenever the occupied count is DEPTH-1, because one slot is always kept empty. An allocation made while full is dropped and leaves `alloc_idx` unchanged.
- R3: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Stores are naturally aligned. Byte k of `wr_data` (bits 8k+7..8k) belongs to address `wr_addr`+k.
- R4: A commit with `commit_seq` retires every occupied slot whose sequence number is below `commit_seq`. A retired slot becomes eligible for writeback once its data has been written, in the same or a later cycle.
- R5: `wb_valid` is 1 in a cycle only if three conditions hold: the slot at the writeback pointer is eligible and not yet written back, and `wb_blocked` is 0. The port then shows that slot's index, address, size and data. Slots drain strictly in allocation order.
- R6: A written-back slot at the head is released on a later cycle, one slot per cycle. Releasing slots clears `sq_full` again.
- R7: A lookup considers only the slots from the writeback pointer (inclusive) up to the load's position (exclusive). Stores already written back and stores younger than the load have no effect.
- R8: A slot whose data has not yet been written is skipped. A data write in the same cycle as a lookup is not seen by that lookup.
- R9: If a store covers the whole load (load start at or after store start, and load end at or before store end), the kind is 1 (forward). The data is the store data shifted right by 8*(load address AND (store bytes-1)), with bytes at and above the load size cleared.
- R10: If the deciding store only partly overlaps the load and has not been written back, the kind is 2 (stall) and the data is 0.
- R11: If no considered store overlaps the load, the kind is 0 (memory) and the data is 0.
- R12: When several considered stores overlap, the youngest one decides the result.
- R13: `res_valid` follows `ld_valid` exactly one cycle later, and the result describes the queue as it stood in the lookup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| sq_full | output | 1 | Queue cannot accept an allocation |
| wr_valid | input | 1 | Write address, size and data into a slot |
| wr_idx | input | IDX_W | Slot being written |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | SZ_W | Store size code |
| wr_data | input | DATA_W | Store data, byte lanes by address offset |
| commit_valid | input | 1 | Retire stores older than `commit_seq` |
| commit_seq | input | SEQ_W | Retirement bound (exclusive) |
| wb_valid | output | 1 | A store is written back this cycle |
| wb_idx | output | IDX_W | Slot being written back |
| wb_addr | output | ADDR_W | Address of the written-back store |
| wb_size | output | SZ_W | Size code of the written-back store |
| wb_data | output | DATA_W | Data of the written-back store |
| wb_blocked | input | 1 | Memory cannot take a store this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_pos | input | IDX_W | Queue position recorded for the load |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size code |
| res_valid | output | 1 | Lookup result valid |
| res_kind | output | 2 | 0 memory, 1 forward, 2 stall |
| res_data | output | DATA_W | Forwarded data, else 0 |

## Verification
Two cases can fall in the same cycle. In the first, a lookup probes a slot while the data-write port fills that slot. In the second, a lookup runs while the writeback port drains the oldest slot it can see. A directed case writes a slot and probes the same address at the same edge, and expects a memory result; a repeat probe one cycle later must forward. The random phase repeats both collisions many times with random blocking. The bench model always evaluates a lookup against the queue state from before that edge, so any leak of same-cycle updates into the result is reported.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        LK_MEM   = 2'd0,
        LK_FWD   = 2'd1,
        LK_STALL = 2'd2
    } lk_kind_e;
endpackage

// File: rtl/sq_match.sv
// Compares one queued store against the probing load.
module sq_match #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int SZ_W   = 2
) (
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic [DATA_W-1:0] st_data,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    output logic              covers,
    output logic              touches,
    output logic [DATA_W-1:0] fwd_data
);
    localparam int BYTES = DATA_W / 8;
    localparam int SH_W  = $clog2(BYTES);

    logic [ADDR_W:0]     st_lo, st_hi, ld_lo, ld_hi;
    logic [SH_W-1:0]     off_mask, byte_off;
    logic [DATA_W-1:0]   lane_mask, shifted;

    always_comb begin
        st_lo = {1'b0, st_addr};
        ld_lo = {1'b0, ld_addr};
        st_hi = st_lo + (ADDR_W+1)'(32'd1 << st_size);
        ld_hi = ld_lo + (ADDR_W+1)'(32'd1 << ld_size);
        covers  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        touches = (ld_lo < st_hi) && (ld_hi > st_lo);

        off_mask = SH_W'((32'd1 << st_size) - 32'd1);
        byte_off = ld_addr[SH_W-1:0] & off_mask;
        shifted  = st_data >> {byte_off, 3'b000};

        lane_mask = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (b < int'(32'd1 << ld_size)) lane_mask[b*8 +: 8] = 8'hFF;
        end
        fwd_data = shifted & lane_mask;
    end
endmodule

// File: rtl/sq_search.sv
// Youngest-first priority search over the live window of the queue.
module sq_search #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int SZ_W   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][SZ_W-1:0]   ent_size,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
    input  logic [DEPTH-1:0]             ent_has,
    input  logic [DEPTH-1:0]             ent_done,
    input  logic [IDX_W-1:0]             wb_ptr,
    input  logic [IDX_W-1:0]             ld_pos,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [SZ_W-1:0]              ld_size,
    output sq_pkg::lk_kind_e             kind,
    output logic [DATA_W-1:0]            data
);
    logic [DEPTH-1:0]   covers, touches;
    logic [DATA_W-1:0]  fwd [DEPTH];
    logic [IDX_W-1:0]   span, idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        sq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SZ_W(SZ_W)) u_cmp (
            .st_addr (ent_addr[i]),
            .st_size (ent_size[i]),
            .st_data (ent_data[i]),
            .ld_addr (ld_addr),
            .ld_size (ld_size),
            .covers  (covers[i]),
            .touches (touches[i]),
            .fwd_data(fwd[i])
        );
    end

    // Walk from oldest to youngest so the youngest qualifying slot wins.
    always_comb begin
        span = ld_pos - wb_ptr;
        kind = sq_pkg::LK_MEM;
        data = '0;
        idx  = '0;
        for (int k = DEPTH - 1; k >= 1; k--) begin
            idx = ld_pos - IDX_W'(k);
            if (k <= int'(span) && ent_has[idx]) begin
                if (covers[idx]) begin
                    kind = sq_pkg::LK_FWD;
                    data = fwd[idx];
                end else if (touches[idx] && !ent_done[idx]) begin
                    kind = sq_pkg::LK_STALL;
                    data = '0;
                end
            end
        end
    end
endmodule

// File: rtl/store_queue.sv
module store_queue #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SZ_W  = $clog2($clog2(DATA_W / 8) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              sq_full,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SZ_W-1:0]   wb_size,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_blocked,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_pos,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [DATA_W-1:0] res_data
);
    typedef struct packed {
        logic              busy;
        logic              has_data;
        logic              can_wb;
        logic              committed;
        logic              completed;
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] addr;
        logic [SZ_W-1:0]   size;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  wbp;
        logic [IDX_W-1:0]  tail;
        logic              res_valid;
        logic [1:0]        res_kind;
        logic [DATA_W-1:0] res_data;
    } state_t;

    state_t s_q, s_d;

    logic [DEPTH-1:0][ADDR_W-1:0] v_addr;
    logic [DEPTH-1:0][SZ_W-1:0]   v_size;
    logic [DEPTH-1:0][DATA_W-1:0] v_data;
    logic [DEPTH-1:0]             v_has, v_done;
    sq_pkg::lk_kind_e             srch_kind;
    logic [DATA_W-1:0]            srch_data;
    logic [IDX_W-1:0]             occupied;
    logic                         full_q, wb_go, free_go;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            v_addr[i] = s_q.slot[i].addr;
            v_size[i] = s_q.slot[i].size;
            v_data[i] = s_q.slot[i].data;
            v_has[i]  = s_q.slot[i].has_data;
            v_done[i] = s_q.slot[i].completed;
        end
    end

    sq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SZ_W(SZ_W)) u_search (
        .ent_addr(v_addr),
        .ent_size(v_size),
        .ent_data(v_data),
        .ent_has (v_has),
        .ent_done(v_done),
        .wb_ptr  (s_q.wbp),
        .ld_pos  (ld_pos),
        .ld_addr (ld_addr),
        .ld_size (ld_size),
        .kind    (srch_kind),
        .data    (srch_data)
    );

    always_comb begin
        s_d      = s_q;
        occupied = s_q.tail - s_q.head;
        full_q   = (occupied == IDX_W'(DEPTH - 1));
        wb_go    = s_q.slot[s_q.wbp].busy && s_q.slot[s_q.wbp].can_wb &&
                   !s_q.slot[s_q.wbp].completed && !wb_blocked;
        free_go  = (s_q.head != s_q.wbp) && s_q.slot[s_q.head].completed;

        if (wb_go) begin
            s_d.slot[s_q.wbp].completed = 1'b1;
            s_d.wbp = s_q.wbp + IDX_W'(1);
        end
        if (free_go) begin
            s_d.slot[s_q.head] = '0;
            s_d.head = s_q.head + IDX_W'(1);
        end
        if (alloc_valid && !full_q) begin
            s_d.slot[s_q.tail]      = '0;
            s_d.slot[s_q.tail].busy = 1'b1;
            s_d.slot[s_q.tail].seq  = alloc_seq;
            s_d.tail = s_q.tail + IDX_W'(1);
        end
        if (wr_valid && s_d.slot[wr_idx].busy) begin
            s_d.slot[wr_idx].addr     = wr_addr;
            s_d.slot[wr_idx].size     = wr_size;
            s_d.slot[wr_idx].data     = wr_data;
            s_d.slot[wr_idx].has_data = 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (commit_valid && s_d.slot[i].busy && (s_d.slot[i].seq < commit_seq))
                s_d.slot[i].committed = 1'b1;
            if (s_d.slot[i].committed && s_d.slot[i].has_data)
                s_d.slot[i].can_wb = 1'b1;
        end

        s_d.res_valid = ld_valid;
        s_d.res_kind  = ld_valid ? srch_kind : sq_pkg::LK_MEM;
        s_d.res_data  = ld_valid ? srch_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alloc_idx = s_q.tail;
    assign sq_full   = full_q;
    assign wb_valid  = wb_go;
    assign wb_idx    = s_q.wbp;
    assign wb_addr   = s_q.slot[s_q.wbp].addr;
    assign wb_size   = s_q.slot[s_q.wbp].size;
    assign wb_data   = s_q.slot[s_q.wbp].data;
    assign res_valid = s_q.res_valid;
    assign res_kind  = s_q.res_kind;
    assign res_data  = s_q.res_data;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic [IDX_W-1:0]  alloc_idx,
    input logic              sq_full,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              wb_blocked,
    input logic              ld_valid,
    input logic              res_valid,
    input logic [1:0]        res_kind,
    input logic [DATA_W-1:0] res_data
);
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && sq_full |=> alloc_idx == $past(alloc_idx));

    p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !sq_full |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1));

    p_blocked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_blocked |-> !wb_valid);

    p_wb_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> wb_idx == IDX_W'($past(wb_idx) + 1'b1));

    p_result_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_valid);

    p_no_stray_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !res_valid);

    p_kind_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_kind != 2'd3);

    p_quiet_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_kind != 2'd1 |-> res_data == '0);
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_store_queue.sv
`timescale 1ns/1ps
module sim_store_queue;
    localparam int D  = 8;
    localparam int IW = 3;
    localparam int SW = 16;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int ZW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          alloc_valid = 0, wr_valid = 0, commit_valid = 0, ld_valid = 0, wb_blocked = 0;
    logic [SW-1:0] alloc_seq = '0, commit_seq = '0;
    logic [IW-1:0] wr_idx = '0, ld_pos = '0;
    logic [AW-1:0] wr_addr = '0, ld_addr = '0;
    logic [ZW-1:0] wr_size = '0, ld_size = '0;
    logic [DW-1:0] wr_data = '0;
    logic [IW-1:0] alloc_idx, wb_idx;
    logic          sq_full, wb_valid, res_valid;
    logic [AW-1:0] wb_addr;
    logic [ZW-1:0] wb_size;
    logic [DW-1:0] wb_data, res_data;
    logic [1:0]    res_kind;

    store_queue #(.DEPTH(D), .SEQ_W(SW), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx), .sq_full(sq_full),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data),
        .wb_blocked(wb_blocked),
        .ld_valid(ld_valid), .ld_pos(ld_pos), .ld_addr(ld_addr), .ld_size(ld_size),
        .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data)
    );

    int errors = 0;
    int checks = 0;

    // Behavioural model of the queue, kept from the requirements.
    int          m_addr [D];
    int          m_sz   [D];
    logic [63:0] m_data [D];
    bit          m_has  [D];
    bit          m_com  [D];
    bit          m_done [D];
    int          m_seq  [D];
    int          m_head = 0, m_wb = 0, m_tail = 0;
    int          next_seq = 1;

    bit          pend = 0;
    int          pend_kind = 0;
    logic [63:0] pend_data = '0;
    string       pend_tag = "";
    string       dtag = "";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int occ();
        return (m_tail - m_head + D) % D;
    endfunction

    function automatic bit live(input int i);
        return ((i - m_head + D) % D) < occ();
    endfunction

    function automatic logic [63:0] lane_mask(input int nbytes);
        if (nbytes >= 8) return '1;
        return (64'd1 << (8 * nbytes)) - 64'd1;
    endfunction

    // Expected lookup outcome against the model before this cycle's updates.
    task automatic expect_lookup(input int pos, input int addr, input int szc,
                                 output int kind, output logic [63:0] data, output string tag);
        int n, idx, sb, lb, sa;
        kind = 0; data = '0; tag = "R11";
        n  = (pos - m_wb + D) % D;
        lb = 1 << szc;
        for (int k = 1; k <= n; k++) begin
            idx = (pos - k + D) % D;
            if (!m_has[idx]) continue;
            sb = 1 << m_sz[idx];
            sa = m_addr[idx];
            if (addr >= sa && addr + lb <= sa + sb) begin
                kind = 1;
                data = (m_data[idx] >> (8 * (addr & (sb - 1)))) & lane_mask(lb);
                tag  = "R3 R9";
                return;
            end
            if (addr < sa + sb && addr + lb > sa && !m_done[idx]) begin
                kind = 2; tag = "R10";
                return;
            end
        end
    endtask

    task automatic clr();
        alloc_valid = 0; wr_valid = 0; commit_valid = 0; ld_valid = 0; wb_blocked = 0;
        dtag = "";
    endtask

    task automatic step();
        int  cnt;
        bit  exp_wb, free_go;
        #1;
        cnt = occ();
        chk(alloc_idx == IW'(m_tail), "R2", "alloc_idx", 64'(alloc_idx), 64'(m_tail));
        chk(sq_full == (cnt >= D - 1), "R2 R6", "sq_full", 64'(sq_full), 64'(cnt >= D - 1));
        exp_wb = (m_wb != m_tail) && m_com[m_wb] && m_has[m_wb] && !m_done[m_wb] && !wb_blocked;
        chk(wb_valid == exp_wb, "R4 R5", "wb_valid", 64'(wb_valid), 64'(exp_wb));
        if (exp_wb && wb_valid)
            chk(wb_idx == IW'(m_wb) && int'(wb_addr) == m_addr[m_wb] &&
                int'(wb_size) == m_sz[m_wb] && wb_data == m_data[m_wb],
                "R5", "wb fields", wb_data, m_data[m_wb]);
        chk(res_valid == pend, "R13", "res_valid", 64'(res_valid), 64'(pend));
        if (pend && res_valid) begin
            chk(int'(res_kind) == pend_kind, pend_tag, "res_kind", 64'(res_kind), 64'(pend_kind));
            chk(res_data == pend_data, pend_tag, "res_data", res_data, pend_data);
        end
        pend = ld_valid;
        if (ld_valid) begin
            expect_lookup(int'(ld_pos), int'(ld_addr), int'(ld_size), pend_kind, pend_data, pend_tag);
            if (dtag != "") pend_tag = dtag;
        end
        free_go = (m_head != m_wb) && m_done[m_head];
        if (exp_wb) begin
            m_done[m_wb] = 1;
            m_wb = (m_wb + 1) % D;
        end
        if (free_go) begin
            m_has[m_head] = 0; m_com[m_head] = 0; m_done[m_head] = 0;
            m_head = (m_head + 1) % D;
        end
        if (alloc_valid && cnt < D - 1) begin
            m_has[m_tail] = 0; m_com[m_tail] = 0; m_done[m_tail] = 0;
            m_seq[m_tail] = int'(alloc_seq);
            m_tail = (m_tail + 1) % D;
        end
        if (wr_valid && live(int'(wr_idx))) begin
            m_addr[wr_idx] = int'(wr_addr);
            m_sz[wr_idx]   = int'(wr_size);
            m_data[wr_idx] = wr_data;
            m_has[wr_idx]  = 1;
        end
        if (commit_valid)
            for (int i = 0; i < D; i++)
                if (live(i) && m_seq[i] < int'(commit_seq)) m_com[i] = 1;
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic do_write(input int idx, input int addr, input int szc, input logic [63:0] dat);
        wr_valid = 1; wr_idx = IW'(idx); wr_addr = AW'(addr); wr_size = ZW'(szc); wr_data = dat;
    endtask

    task automatic do_load(input int pos, input int addr, input int szc, input string tag);
        ld_valid = 1; ld_pos = IW'(pos); ld_addr = AW'(addr); ld_size = ZW'(szc); dtag = tag;
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) begin
            m_has[i] = 0; m_com[i] = 0; m_done[i] = 0; m_seq[i] = 0; m_addr[i] = 0; m_sz[i] = 0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(alloc_idx == '0, "R1", "alloc_idx", 64'(alloc_idx), 64'd0);
        chk(sq_full == 1'b0, "R1", "sq_full", 64'(sq_full), 64'd0);
        chk(wb_valid == 1'b0, "R1", "wb_valid", 64'(wb_valid), 64'd0);
        chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);

        // R2: fill to the sentinel limit, last allocation dropped
        for (int i = 0; i < D; i++) begin
            alloc_valid = 1; alloc_seq = SW'(next_seq); next_seq++;
            step();
        end
        do_write(0, 'h10, 3, 64'h8877665544332211); step();
        do_write(1, 'h14, 2, 64'h00000000AABBCCDD); step();
        do_write(3, 'h12, 0, 64'h000000000000005A); step();

        do_load(4, 'h12, 0, "R12"); step();     // youngest covering store wins
        do_load(3, 'h14, 1, "R8");  step();     // slot 2 has no data, slot 1 forwards CCDD
        do_load(2, 'h14, 3, "R10"); step();     // partial overlap with slot 1
        do_load(1, 'h13, 0, "R9");  step();     // byte 3 of slot 0 -> 44
        do_load(1, 'h20, 0, "R11"); step();     // no overlap
        do_load(0, 'h10, 3, "R7");  step();     // empty window
        // same-cycle data write and lookup
        do_write(2, 'h30, 2, 64'h0000000012345678);
        do_load(3, 'h30, 2, "R8"); step();
        do_load(3, 'h30, 2, "R9"); step();
        // retire slots 0 and 1, hold memory off once
        commit_valid = 1; commit_seq = SW'(m_seq[1] + 1); step();
        wb_blocked = 1; step();
        step(); step(); step(); step();
        do_load(2, 'h14, 2, "R7"); step();      // slot 1 already written back
        step();

        // Random phase
        for (int c = 0; c < 3000; c++) begin
            int cnt, r, idx, sz, span;
            cnt = occ();
            if ($urandom % 2 == 0) begin
                alloc_valid = 1; alloc_seq = SW'(next_seq); next_seq++;
            end
            if (cnt > 0) begin
                r = int'($urandom % cnt);
                idx = (m_head + r) % D;
                if (!m_has[idx] && $urandom % 2 == 0) begin
                    sz = int'($urandom % 4);
                    do_write(idx, int'(($urandom % (32 >> sz)) << sz), sz, {$urandom, $urandom});
                end
                if ($urandom % 5 == 0) begin
                    commit_valid = 1;
                    commit_seq = SW'(m_seq[(m_head + int'($urandom % cnt)) % D] + 1);
                end
            end
            if ($urandom % 3 != 0) begin
                span = (m_tail - m_wb + D) % D;
                sz = int'($urandom % 4);
                do_load((m_wb + int'($urandom % (span + 1))) % D,
                        int'(($urandom % (32 >> sz)) << sz), sz, "");
            end
            wb_blocked = ($urandom % 4 == 0);
            step();
        end
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule